// File: doc/BRIEF.md
# Real-time clock alarm comparator and interrupt flag collector

This block sits beside the timekeeping counters of a real-time clock. It holds three alarm bytes, one each for seconds, minutes and hours. On every update-finished pulse from the counters it compares the current time against those bytes. An alarm byte whose top two bits are both one acts as a wildcard for its field.

The block gathers three kinds of event into one flag byte: periodic ticks, alarm hits and update completions. The host sets a separate enable for each kind in a control byte. A summary bit in the flag byte, and the `irq` output with it, is high while any flag is set together with its enable.

The host reaches the block over a simple register bus with write and read strobes. Read data appears one cycle after the read strobe. Reading the flag byte returns its contents and clears every flag in the same edge. An event that lands in that same cycle survives the clear.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After an active-low reset, all alarm bytes, the control byte, every flag, `bus_rdata` and `irq` are zero.
- R2: Host writes to address 1 (seconds alarm), 3 (minutes alarm), 5 (hours alarm) and 11 (control) store the byte. A read of the same address returns the stored byte on `bus_rdata` in the cycle after the read strobe. `bus_rdata` holds its value while no read strobe is given.
- R3: An update pulse (`tick_upd`) while all three time fields equal their alarm bytes sets the alarm flag, bit 5 of the flag byte.
- R4: An alarm byte with bits 7 and 6 both one (value 0xC0 or above) matches any value of its time field.
- R5: The alarm flag is not set if any non-wildcard field differs at the update pulse. It is also not set in cycles without an update pulse, even while the fields keep matching, so one update sets it at most once.
- R6: `tick_per` sets the periodic flag (bit 6) and `tick_upd` sets the update flag (bit 4), whether or not their enables are set.
- R7: The control byte enables are bit 6 for periodic, bit 5 for alarm and bit 4 for update. Flag bit 7 is one exactly when some flag is set together with its enable, and `irq` equals flag bit 7.
- R8: A read of address 12 returns the flag byte, including bit 7, as it stood before the read. It clears all flags, so bit 7 and `irq` drop in the next cycle.
- R9: An event arriving in the same cycle as the clearing read is set after the clear. The value returned by that read does not include it.
- R10: Reads of unmapped addresses return zero and leave the flags unchanged. Writes to address 12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_sec | input | 8 | Current seconds field |
| time_min | input | 8 | Current minutes field |
| time_hour | input | 8 | Current hours field |
| tick_per | input | 1 | Periodic event pulse |
| tick_upd | input | 1 | Update-finished pulse; also the alarm compare strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 4 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, registered |
| flag_vec | output | 8 | Live flag byte: bit 7 summary, bits 6..4 flags |
| irq | output | 1 | Active-high interrupt request |

## Verification
The clearing read of the flag byte and the arrival of a new event can share a clock edge. The bench provokes this twice. First it reads address 12 while pulsing `tick_per`. Then it reads address 12 while pulsing `tick_upd` with a matching alarm, so two flags rise against the clear at once. Each time it judges that the returned byte shows only the old flags, and that the flag byte in the next cycle holds exactly the new events with a summary bit that follows the current enables. A behavioural reference model, run on every clock, cross-checks all the other cycles.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and types for the alarm/interrupt flag unit.
// Assumes an 8-bit register bus; bit positions are fixed by software.
package rtc_alarm_pkg;
    localparam int ADR_ALM_BASE = 1;   // seconds alarm
    localparam int ADR_ALM_STEP = 2;   // minutes at 3, hours at 5
    localparam int ADR_CTL      = 11;
    localparam int ADR_FLG      = 12;

    localparam int BIT_IRQF = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_ALM  = 5;
    localparam int BIT_UPD  = 4;

    // One bit per event source, ordered like the flag byte.
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_t;
endpackage

// File: rtl/rtc_alarm_match.sv
// Compares NF time fields against NF alarm bytes.
// A byte with both top bits set matches anything. Purely combinational.
// Assumes DW >= 2.
module rtc_alarm_match #(
    parameter int DW = 8,
    parameter int NF = 3
) (
    input  logic [NF*DW-1:0] alarm_flat,
    input  logic [NF*DW-1:0] now_flat,
    output logic             all_hit
);
    logic [NF-1:0] hit;

    for (genvar gi = 0; gi < NF; gi++) begin : g_fld
        logic [DW-1:0] a_b;
        logic [DW-1:0] t_b;
        logic          wild;
        assign a_b  = alarm_flat[gi*DW +: DW];
        assign t_b  = now_flat[gi*DW +: DW];
        assign wild = a_b[DW-1] & a_b[DW-2];
        // field matches when wildcard or equal
        assign hit[gi] = wild | (a_b == t_b);
    end

    assign all_hit = &hit;
endmodule

// File: rtl/rtc_alarm_regs.sv
// Host-visible register file: alarm bytes, control byte, read mux.
// Produces the flag-clear strobe.
// Assumes at most one access per cycle matters; write and read are independent.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int NF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    flag_view,
    output logic [NF*DW-1:0] alarm_flat,
    output evt_t             en,
    output logic             rd_clr,
    output logic [DW-1:0]    bus_rdata
);
    logic [DW-1:0] alm_q [NF];
    logic [DW-1:0] ctl_q;
    logic [DW-1:0] rd_mux;

    for (genvar gi = 0; gi < NF; gi++) begin : g_alm
        localparam logic [AW-1:0] ADR = AW'(ADR_ALM_BASE + ADR_ALM_STEP * gi);
        // store one alarm byte on a host write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)                          alm_q[gi] <= '0;
            else if (bus_wr && bus_addr == ADR)  alm_q[gi] <= bus_wdata;
        end
        assign alarm_flat[gi*DW +: DW] = alm_q[gi];
    end

    // store the control byte
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ctl_q <= '0;
        else if (bus_wr && bus_addr == AW'(ADR_CTL))  ctl_q <= bus_wdata;
    end

    assign en.per = ctl_q[BIT_PER];
    assign en.alm = ctl_q[BIT_ALM];
    assign en.upd = ctl_q[BIT_UPD];

    // select read data by address; unmapped reads give zero
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NF; i++)
            if (bus_addr == AW'(ADR_ALM_BASE + ADR_ALM_STEP * i)) rd_mux = alm_q[i];
        if (bus_addr == AW'(ADR_CTL)) rd_mux = ctl_q;
        if (bus_addr == AW'(ADR_FLG)) rd_mux = flag_view;
    end

    assign rd_clr = bus_rd && (bus_addr == AW'(ADR_FLG));

    // register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_rdata <= '0;
        else if (bus_rd)  bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/rtc_flag_unit.sv
// Holds the three event flags, clears them on a flag read, and forms the summary/irq.
// New events win over a same-cycle clear. Assumes DW >= 8.
module rtc_flag_unit
    import rtc_alarm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  evt_t          ev,
    input  evt_t          en,
    input  logic          clr,
    output logic [DW-1:0] flag_view,
    output logic          irq
);
    evt_t fl_q;
    logic irqf;

    // accumulate events; clear on read but keep same-cycle arrivals
    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= (clr ? evt_t'('0) : fl_q) | ev;
    end

    assign irqf = |(fl_q & en);
    assign irq  = irqf;

    // assemble the byte seen by the host
    always_comb begin
        flag_view           = '0;
        flag_view[BIT_IRQF] = irqf;
        flag_view[BIT_PER]  = fl_q.per;
        flag_view[BIT_ALM]  = fl_q.alm;
        flag_view[BIT_UPD]  = fl_q.upd;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
// Top: alarm compare on update pulses plus interrupt flag collection.
// Time fields must be stable in the cycle carrying tick_upd.
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] time_sec,
    input  logic [DW-1:0] time_min,
    input  logic [DW-1:0] time_hour,
    input  logic          tick_per,
    input  logic          tick_upd,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] flag_vec,
    output logic          irq
);
    localparam int NF = 3;

    logic [NF*DW-1:0] alarm_flat;
    logic [NF*DW-1:0] now_flat;
    logic             all_hit;
    logic             rd_clr;
    evt_t             ctl_en;
    evt_t             ev;

    assign now_flat = {time_hour, time_min, time_sec};

    rtc_alarm_regs #(.DW(DW), .AW(AW), .NF(NF)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag_view(flag_vec),
        .alarm_flat(alarm_flat), .en(ctl_en), .rd_clr(rd_clr), .bus_rdata(bus_rdata)
    );

    rtc_alarm_match #(.DW(DW), .NF(NF)) u_match (
        .alarm_flat(alarm_flat), .now_flat(now_flat), .all_hit(all_hit)
    );

    // events of this cycle; alarm is only judged on an update pulse
    assign ev.per = tick_per;
    assign ev.upd = tick_upd;
    assign ev.alm = tick_upd & all_hit;

    rtc_flag_unit #(.DW(DW)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev), .en(ctl_en), .clr(rd_clr),
        .flag_view(flag_vec), .irq(irq)
    );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
// Protocol checks for rtc_alarm_irq, bound to the top.
module rtc_alarm_irq_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_per,
    input logic          tick_upd,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] flag_vec,
    input logic          irq,
    input logic [2:0]    en_bits
);
    logic flg_rd;
    assign flg_rd = bus_rd && (bus_addr == AW'(12));

    // R6
    per_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_per |=> flag_vec[6]);
    // R6
    upd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_upd |=> flag_vec[4]);
    // R5
    alarm_only_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_vec[5]) |-> $past(tick_upd));
    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_vec[6:4] & en_bits) != 3'b000));
    // R8
    read_returns_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flg_rd |=> bus_rdata == $past(flag_vec));
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_rd && !tick_per && !tick_upd) |=> (flag_vec[6:4] == 3'b000) && !irq);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_per(tick_per), .tick_upd(tick_upd),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .flag_vec(flag_vec), .irq(irq), .en_bits(ctl_en)
);

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] time_sec = '0, time_min = '0, time_hour = '0;
    logic       tick_per = 1'b0, tick_upd = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, flag_vec;
    logic       irq;

    int n_chk = 0, n_bad = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_irq u_dut (
        .clk(clk), .rst_n(rst_n), .time_sec(time_sec), .time_min(time_min),
        .time_hour(time_hour), .tick_per(tick_per), .tick_upd(tick_upd),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_vec(flag_vec), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_alm [3];
    logic [7:0] m_ctl, m_rd;
    bit         m_per, m_al, m_up;

    function automatic bit fld_ok(input logic [7:0] a, input logic [7:0] t);
        return (a >= 8'hC0) || (a == t);
    endfunction

    function automatic logic [7:0] m_view();
        bit s;
        s = (m_per && m_ctl[6]) || (m_al && m_ctl[5]) || (m_up && m_ctl[4]);
        return {s, m_per, m_al, m_up, 4'h0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_alm[0] <= 0; m_alm[1] <= 0; m_alm[2] <= 0;
            m_ctl <= 0; m_rd <= 0; m_per <= 0; m_al <= 0; m_up <= 0;
        end else begin
            bit clr, hit;
            clr = bus_rd && bus_addr == 4'd12;
            hit = fld_ok(m_alm[0], time_sec) && fld_ok(m_alm[1], time_min)
                  && fld_ok(m_alm[2], time_hour);
            if (bus_wr) begin
                if (bus_addr == 4'd1)  m_alm[0] <= bus_wdata;
                if (bus_addr == 4'd3)  m_alm[1] <= bus_wdata;
                if (bus_addr == 4'd5)  m_alm[2] <= bus_wdata;
                if (bus_addr == 4'd11) m_ctl    <= bus_wdata;
            end
            if (bus_rd) begin
                case (bus_addr)
                    4'd1:    m_rd <= m_alm[0];
                    4'd3:    m_rd <= m_alm[1];
                    4'd5:    m_rd <= m_alm[2];
                    4'd11:   m_rd <= m_ctl;
                    4'd12:   m_rd <= m_view();
                    default: m_rd <= 8'h00;
                endcase
            end
            m_per <= (clr ? 1'b0 : m_per) | tick_per;
            m_up  <= (clr ? 1'b0 : m_up)  | tick_upd;
            m_al  <= (clr ? 1'b0 : m_al)  | (tick_upd && hit);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // per-clock comparison with the model, at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(flag_vec === m_view(), "R6 R7 flag byte vs model", flag_vec, m_view());
            chk(irq === m_view()[7], "R7 irq vs model", {7'h0, irq}, {7'h0, m_view()[7]});
            chk(bus_rdata === m_rd, "R8 rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_rd = 1; bus_addr = a;
        step();
        d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic upd();
        tick_upd = 1; step(); tick_upd = 0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(flag_vec === 8'h00, "R1 flags at reset", flag_vec, 8'h00);
        chk(irq === 1'b0, "R1 irq at reset", {7'h0, irq}, 8'h00);
        chk(bus_rdata === 8'h00, "R1 rdata at reset", bus_rdata, 8'h00);
        rst_n = 1;
        step();
        rd(4'd5, rv); chk(rv === 8'h00, "R1 hours alarm reset", rv, 8'h00);
        rd(4'd11, rv); chk(rv === 8'h00, "R1 control reset", rv, 8'h00);

        // R2 register write/readback
        wr(4'd1, 8'h30); wr(4'd3, 8'h15); wr(4'd5, 8'h07); wr(4'd11, 8'hF0);
        rd(4'd1, rv);  chk(rv === 8'h30, "R2 seconds alarm", rv, 8'h30);
        rd(4'd3, rv);  chk(rv === 8'h15, "R2 minutes alarm", rv, 8'h15);
        rd(4'd5, rv);  chk(rv === 8'h07, "R2 hours alarm", rv, 8'h07);
        rd(4'd11, rv); chk(rv === 8'hF0, "R2 control", rv, 8'hF0);
        step();
        chk(bus_rdata === 8'hF0, "R2 rdata holds without strobe", bus_rdata, 8'hF0);

        // R5 matching time but no update pulse
        time_sec = 8'h30; time_min = 8'h15; time_hour = 8'h07;
        repeat (3) step();
        chk(flag_vec === 8'h00, "R5 no flag without update", flag_vec, 8'h00);

        // R3 full match on update
        upd();
        chk(flag_vec === 8'hB0, "R3 alarm+update flags", flag_vec, 8'hB0);
        chk(irq === 1'b1, "R7 irq raised", {7'h0, irq}, 8'h01);
        repeat (2) step();
        chk(flag_vec === 8'hB0, "R5 held match adds nothing", flag_vec, 8'hB0);

        // R8 clearing read
        rd(4'd12, rv);
        chk(rv === 8'hB0, "R8 read returns flags", rv, 8'hB0);
        chk(flag_vec === 8'h00, "R8 flags cleared", flag_vec, 8'h00);
        chk(irq === 1'b0, "R8 irq dropped", {7'h0, irq}, 8'h00);

        // R5 seconds mismatch
        time_sec = 8'h31;
        upd();
        chk(flag_vec === 8'h90, "R5 mismatch no alarm", flag_vec, 8'h90);
        rd(4'd12, rv);

        // R4 wildcards on seconds and minutes
        wr(4'd1, 8'hC5); wr(4'd3, 8'hFF);
        time_sec = 8'h59; time_min = 8'h42; time_hour = 8'h07;
        upd();
        chk(flag_vec === 8'hB0, "R4 wildcard match", flag_vec, 8'hB0);
        rd(4'd12, rv);
        time_hour = 8'h08;
        upd();
        chk(flag_vec === 8'h90, "R5 hour mismatch with wildcards", flag_vec, 8'h90);
        rd(4'd12, rv);

        // R6 R7 flags without enables, then enable selection
        wr(4'd11, 8'h00);
        tick_per = 1; step(); tick_per = 0;
        chk(flag_vec === 8'h40, "R6 periodic flag with enable off", flag_vec, 8'h40);
        chk(irq === 1'b0, "R7 no irq when disabled", {7'h0, irq}, 8'h00);
        wr(4'd11, 8'h40);
        chk(flag_vec === 8'hC0, "R7 summary after enable", flag_vec, 8'hC0);
        chk(irq === 1'b1, "R7 irq after enable", {7'h0, irq}, 8'h01);
        wr(4'd11, 8'h20);
        chk(irq === 1'b0, "R7 irq follows other enable", {7'h0, irq}, 8'h00);

        // R9 event in the same cycle as the clearing read
        tick_per = 1; bus_rd = 1; bus_addr = 4'd12;
        step();
        tick_per = 0; bus_rd = 0;
        chk(bus_rdata === 8'h40, "R9 read value excludes new event", bus_rdata, 8'h40);
        chk(flag_vec === 8'h40, "R9 periodic kept over clear", flag_vec, 8'h40);
        time_hour = 8'h07;
        tick_upd = 1; bus_rd = 1; bus_addr = 4'd12;
        step();
        tick_upd = 0; bus_rd = 0;
        chk(bus_rdata === 8'h40, "R9 read value before update", bus_rdata, 8'h40);
        chk(flag_vec === 8'hB0, "R9 alarm and update kept", flag_vec, 8'hB0);

        // R10 unmapped read and write to flag address
        rd(4'd0, rv);
        chk(rv === 8'h00, "R10 unmapped read zero", rv, 8'h00);
        chk(flag_vec === 8'hB0, "R10 unmapped read keeps flags", flag_vec, 8'hB0);
        wr(4'd12, 8'h00);
        chk(flag_vec === 8'hB0, "R10 write to flags ignored", flag_vec, 8'hB0);
        rd(4'd12, rv);
        chk(rv === 8'hB0, "R8 final read", rv, 8'hB0);
        chk(flag_vec === 8'h00, "R8 final clear", flag_vec, 8'h00);

        step();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule